// File: doc/BRIEF.md
# Bit-serial adder

This block adds two unsigned W-bit operands with a single full-adder cell. The operands arrive one bit of each per clock, lowest bit first. The sum leaves in the same order, one registered bit per clock. A one-bit register carries the carry from each bit position into the next one.

A word starts with any valid cycle that has the start flag set. The block counts the valid bits of the word. When the W-th bit has been consumed, the final carry is presented with a one-cycle qualifier. The stored carry is then cleared, so the next word may begin on the very next cycle. Asserting the start flag forces the carry-in to zero at any time, even in the middle of a word, and the count starts again from that bit.

Cycles with the valid input low are bubbles. They may appear anywhere, inside a word or between words. A bubble changes no state and produces no output qualifier.

Top module: `serial_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, sum_o, sum_vld_o, carry_o and carry_vld_o are all 0.
- R2: For a cycle with vld_i=1, on the next cycle sum_vld_o=1 and sum_o equals a_i XOR b_i XOR the carry-in of that bit. After a cycle with vld_i=0, sum_vld_o=0 on the next cycle.
- R3: On a valid cycle with first_i=1, the carry-in is 0, whatever carry the previous bit left behind.
- R4: On a valid cycle with first_i=0, the carry-in is the carry-out of the previous valid bit of the same word.
- R5: A cycle with vld_i=0 leaves the stored carry, the bit position, sum_o and carry_o unchanged, whatever values first_i, a_i and b_i have on that cycle.
- R6: One cycle after the W-th valid bit of a word (counted from bit 0), carry_vld_o=1 for exactly one cycle and carry_o equals that bit's carry-out. carry_o holds its value until the next such pulse.
- R7: The carry-out of a word's top bit never enters the next word. This holds when the next word follows with no idle cycle, and it also holds when the next word's first bit lacks first_i.
- R8: For streams of words with random gaps, the W sum bits gathered lowest first, with carry_o as bit W, equal the (W+1)-bit sum of the two operands.
- R9: first_i on a valid cycle in the middle of a word restarts the bit count. The final-carry pulse then comes W valid bits after that restart bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Operand bits on this cycle are valid |
| first_i | input | 1 | This valid bit is bit 0 of a word |
| a_i | input | 1 | Operand A bit |
| b_i | input | 1 | Operand B bit |
| sum_o | output | 1 | Registered sum bit |
| sum_vld_o | output | 1 | sum_o holds a new bit |
| carry_o | output | 1 | Final carry of the last finished word |
| carry_vld_o | output | 1 | One-cycle pulse: carry_o is new |

## Verification
The directed cases target the carry at word boundaries. One word ends with carry 1 and the next starts with no gap. A design that leaked that carry would show a 1 in bit 0 of an all-zero result. Another case restarts a word in the middle while the carry is set. A design that ignored the restart would add a stray 1 and pulse the final carry too early. Bubbles are placed between bits that have a pending carry, so a design that lost or advanced its state during a bubble gives a wrong upper sum. Random words with random gaps, some started without the flag, are gathered back into parallel form and compared with a plain addition.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  // width of a bit-position index for a word of w bits (at least 1)
  function automatic int idx_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;
  always_comb begin
    half = x_i ^ y_i;
    s_o  = half ^ c_i;
    c_o  = (x_i & y_i) | (half & c_i);
  end
endmodule

// File: rtl/sa_carry_reg.sv
module sa_carry_reg (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic squash_i,
  input  logic clear_i,
  input  logic cout_i,
  output logic cin_o
);
  logic c_q;
  // start of word forces a zero carry-in
  assign cin_o = squash_i ? 1'b0 : c_q;
  always_ff @(posedge clk) begin
    if (rst) c_q <= 1'b0;
    else if (en_i) c_q <= clear_i ? 1'b0 : cout_i;
  end
endmodule

// File: rtl/sa_position.sv
module sa_position #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic restart_i,
  output logic last_o
);
  localparam int CW = serial_adder_pkg::idx_width(W);
  localparam logic [CW-1:0] TOP = CW'(W - 1);
  logic [CW-1:0] pos_q;
  logic [CW-1:0] idx;
  assign idx    = restart_i ? '0 : pos_q;
  assign last_o = (idx == TOP);
  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else if (adv_i) pos_q <= last_o ? '0 : idx + CW'(1);
  end
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  logic first_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic sum_vld_o,
  output logic carry_o,
  output logic carry_vld_o
);
  logic cin, s_bit, c_bit, last;
  logic restart;
  assign restart = vld_i & first_i;

  sa_position #(.W(W)) u_pos (
    .clk(clk), .rst(rst), .adv_i(vld_i), .restart_i(restart), .last_o(last)
  );

  sa_carry_reg u_carry (
    .clk(clk), .rst(rst), .en_i(vld_i), .squash_i(restart),
    .clear_i(last), .cout_i(c_bit), .cin_o(cin)
  );

  sa_full_adder u_fa (
    .x_i(a_i), .y_i(b_i), .c_i(cin), .s_o(s_bit), .c_o(c_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o       <= 1'b0;
      sum_vld_o   <= 1'b0;
      carry_o     <= 1'b0;
      carry_vld_o <= 1'b0;
    end else begin
      sum_vld_o   <= vld_i;
      carry_vld_o <= vld_i & last;
      if (vld_i) sum_o <= s_bit;
      if (vld_i && last) carry_o <= c_bit;
    end
  end
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk (
  input logic clk,
  input logic rst,
  input logic vld_i,
  input logic first_i,
  input logic a_i,
  input logic b_i,
  input logic sum_o,
  input logic sum_vld_o,
  input logic carry_o,
  input logic carry_vld_o
);
  // R2
  sum_qual_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> sum_vld_o);
  // R2
  bubble_qual_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !sum_vld_o);
  // R3
  first_zero_cin_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && first_i) |=> (sum_o == ($past(a_i) ^ $past(b_i))));
  // R5
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(sum_o) && $stable(carry_o)));
  // R6
  carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    carry_vld_o |-> sum_vld_o);
  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_vld_o |=> (carry_vld_o || $stable(carry_o)));
endmodule

bind serial_adder serial_adder_chk u_chk (.*);

// File: tb/serial_adder_bench.sv
`timescale 1ns/1ps
module serial_adder_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld_i = 0, first_i = 0, a_i = 0, b_i = 0;
  logic sum_o, sum_vld_o, carry_o, carry_vld_o;
  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  bit m_carry = 0;
  int m_pos = 0;
  bit e_sum = 0, e_svld = 0, e_cout = 0, e_cvld = 0;

  always #2.5 clk = ~clk;

  serial_adder #(.W(W)) u_serial_adder (
    .clk(clk), .rst(rst), .vld_i(vld_i), .first_i(first_i), .a_i(a_i), .b_i(b_i),
    .sum_o(sum_o), .sum_vld_o(sum_vld_o), .carry_o(carry_o), .carry_vld_o(carry_vld_o)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs at the following negedge
  task automatic cyc(input bit v, input bit f, input bit a, input bit b, input string tag);
    bit cin, co, last;
    int idx;
    if (v) begin
      cin = f ? 1'b0 : m_carry;
      co = (a & b) | (a & cin) | (b & cin);
      idx = f ? 0 : m_pos;
      last = (idx == W - 1);
      e_sum = a ^ b ^ cin;
      e_svld = 1;
      e_cvld = last;
      if (last) e_cout = co;
      m_carry = last ? 1'b0 : co;
      m_pos = last ? 0 : idx + 1;
    end else begin
      e_svld = 0;
      e_cvld = 0;
    end
    vld_i = v; first_i = f; a_i = a; b_i = b;
    @(negedge clk);
    chk(tag, "sum_vld_o", sum_vld_o, e_svld);
    chk(tag, "sum_o", sum_o, e_sum);
    chk(tag, "carry_vld_o", carry_vld_o, e_cvld);
    chk(tag, "carry_o", carry_o, e_cout);
  endtask

  task automatic word(input logic [W-1:0] a, input logic [W-1:0] b, input bit use_first,
                      input int gap_pct, input string tag);
    logic [W:0] got;
    logic [W:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    for (int k = 0; k < W; k++) begin
      while (($urandom % 100) < gap_pct)
        cyc(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), "R5");
      cyc(1'b1, (k == 0) && use_first, a[k], b[k], tag);
      got[k] = sum_o;
    end
    got[W] = carry_o;
    chk("R8", "word sum", int'(got), int'(ref_sum));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    // R1 during and right after reset
    chk("R1", "sum_vld_o", sum_vld_o, 0);
    chk("R1", "carry_vld_o", carry_vld_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "sum_o", sum_o, 0);
    chk("R1", "carry_o", carry_o, 0);

    // R4 / R5 / R6: FF + 01 with bubbles while carry is pending
    cyc(1, 1, 1, 1, "R4");
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 1, 1, 1, "R5");
    for (int k = 1; k < W; k++) cyc(1, 0, 1, 0, "R4");
    chk("R6", "final carry of FF+01", carry_o, 1);
    // R7: zero word right behind, no idle cycle
    for (int k = 0; k < W; k++) cyc(1, k == 0, 0, 0, "R7");
    chk("R7", "carry after zero word", carry_o, 0);
    // R7: carry-1 word, then zero word with no start flag
    for (int k = 0; k < W; k++) cyc(1, k == 0, 1, 1, "R6");
    for (int k = 0; k < W; k++) cyc(1, 0, 0, 0, "R7");
    // R3 / R9: restart in the middle while carry is set
    cyc(1, 1, 1, 1, "R4");
    cyc(1, 0, 1, 1, "R4");
    cyc(1, 1, 0, 0, "R3");
    chk("R3", "sum at restart", sum_o, 0);
    for (int k = 1; k < W; k++) cyc(1, 0, 0, 1, "R9");
    chk("R9", "carry pulse after restart", carry_vld_o, 1);

    // R2 / R8: random words with random gaps
    for (int n = 0; n < 300; n++)
      word(W'($urandom), W'($urandom), ($urandom % 4) != 0, 20, "R2");
    // boundary operands
    word('1, '1, 1, 0, "R2");
    word('0, '0, 1, 0, "R2");
    word('1, W'(1), 0, 0, "R2");
    cyc(0, 0, 0, 0, "R2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule